// File: doc/BRIEF.md
# Pixel Cell Trigger-Latency Buffer

This block is the digital back end of a single cell in a triggered hybrid pixel readout. It takes the discriminator output of the cell, or a global test strobe when test injection is enabled, and brings it into the system clock domain through a synchroniser. It then times each new hit with one of two independent delay counters. A hit is kept only if the level-1 trigger is high in the exact cycle its counter runs out. Kept hits go into a four-entry event queue as a hit bit plus an event tag. A readout request shifts the oldest event out.

The cell holds five static configuration bits: a mask, a test-injection enable and a 3-bit threshold-trim code, of which only the trim code leaves the block. These bits enter through a serial shift chain that can be daisy-chained from cell to cell, and a load strobe copies the chain into the working latches. A combinational fast-OR output reports any unmasked hit at once, for self-triggering. A sticky overflow flag records every hit or event that was lost. The intended system clock is 10 MHz.

Top module: `pix_trig_cell`

## Requirements
- R1: After synchronous active-low reset, rd_data is 0, overflow is 0, fast_or is 0, trim_code is 0, cfg_sout is 0 and the event tag counter is 0.
- R2: fast_or is combinational and is 1 in any cycle where disc_hit is 1 and the cell is unmasked.
- R3: With the mask bit set, disc_hit and test_strobe raise neither fast_or nor any stored event.
- R4: If disc_hit is first sampled high at clock edge e, the hit is stored only if l1_trig is sampled high at edge e+latency+3. A trigger one cycle early or late discards the hit. This holds for latency 0 as well.
- R5: Two hits whose delay windows overlap are timed independently, and each can be stored by its own trigger.
- R6: A hit that starts while both delay units are busy is dropped and sets overflow. Overflow then stays 1 until reset.
- R7: The queue holds four events and reads them out oldest first. rd_data is {1'b1, tag}, where the 1 is bit 4 and tag (bits 3:0) is the number of cycles in which l1_trig was high since reset, counted before the matching cycle, modulo 16.
- R8: A read request with the queue empty loads rd_data with 0.
- R9: A match with four events queued and no read in that cycle is dropped and sets overflow.
- R10: A match and a read in the same cycle with the queue full both take effect: the oldest event leaves, the new one is stored and overflow stays 0.
- R11: Each cycle with cfg_shift high shifts cfg_sin in, and cfg_sout shows the bit shifted in five shifts earlier. cfg_load copies the chain into the latches as {trim[2:0], test_en, mask}, with the first bit shifted in becoming trim bit 2 and the last becoming the mask.
- R12: The configuration latches change only on cfg_load. They are unaffected by shifting, hits, triggers and reads.
- R13: With test_en set and the mask clear, test_strobe acts as a discriminator hit, both for fast_or and for storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_hit | input | 1 | Discriminator output of the cell |
| test_strobe | input | 1 | Global test-pulse strobe |
| l1_trig | input | 1 | Level-1 trigger |
| latency | input | 8 | Trigger latency in clock cycles, shared by both delay units |
| rd_req | input | 1 | Pops the oldest event into rd_data |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_load | input | 1 | Copies the chain into the configuration latches |
| cfg_sout | output | 1 | Serial configuration data out, for the next cell |
| trim_code | output | 3 | Threshold-trim code held in the latches |
| fast_or | output | 1 | Combinational unmasked-hit indicator |
| rd_data | output | 5 | Last event read: {hit, tag}, or 0 |
| overflow | output | 1 | Sticky lost-hit or lost-event flag |

## Verification
Two of this block's functions can fall in the same cycle: storing a triggered event and popping the oldest one while the queue is full. The bench fills the queue with four triggered hits. It then lines up a fifth trigger coincidence so that it lands on the same clock edge as a read request. The outcome is judged at the ports: the read must return the oldest tag, overflow must stay clear, and the four later reads must return the remaining tags in order, including the new one. A second collision, a hit arriving while both delay units are busy, is provoked with a long latency and three closely spaced hits. It is judged by which tags come out and by the overflow flag.

// File: rtl/pxc_pkg.sv
// Package: configuration layout shared by the pixel-cell modules.
// Assumes a five-bit chain: {trim[2:0], test_en, mask}, mask at bit 0.
package pxc_pkg;
    localparam int CFG_W    = 5;
    localparam int TRIM_W   = 3;
    localparam int MASK_BIT = 0;
    localparam int TEN_BIT  = 1;
    localparam int TRIM_LSB = 2;
endpackage

// File: rtl/pxc_cfg_chain.sv
// Serial configuration chain and working latches of one cell.
// Shifting moves data toward cfg_sout. The latches change only on load.
// Assumes shift and load are driven by a slow, static configuration sequence.
module pxc_cfg_chain
    import pxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin,
    input  logic              shift_en,
    input  logic              load,
    output logic              sout,
    output logic              mask,
    output logic              test_en,
    output logic [TRIM_W-1:0] trim
);
    logic [CFG_W-1:0] chain_q;
    logic [CFG_W-1:0] lat_q;

    // Shift register: new bit enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[CFG_W-2:0], sin};
    end

    // Working latches: copied from the chain on load only.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat_q <= '0;
        else if (load) lat_q <= chain_q;
    end

    assign sout    = chain_q[CFG_W-1];
    assign mask    = lat_q[MASK_BIT];
    assign test_en = lat_q[TEN_BIT];
    assign trim    = lat_q[TRIM_LSB +: TRIM_W];

    // R12: latches hold whenever no load is seen
    a_r12_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lat_q));
endmodule

// File: rtl/pxc_delay_unit.sv
// One delay unit: times a single hit for 'latency' cycles after loading.
// expire is high for one cycle when the count reaches zero, and the unit
// frees itself in that same cycle. Assumes start only when free or expiring.
module pxc_delay_unit #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] latency,
    output logic             busy,
    output logic             expire
);
    logic [LAT_W-1:0] cnt_q;

    assign expire = busy && (cnt_q == '0);

    // Load on start, count down while busy, release on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= latency;
        end else if (expire) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: a unit still counting stays busy in the next cycle
    a_r4_keeps_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0 && !start) |=> busy);
    // R4: expiry without a restart frees the unit
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !busy);
endmodule

// File: rtl/pxc_event_fifo.sv
// Event queue of DEPTH entries with a registered read port.
// A pop loads out_q with the oldest entry, or with zero when empty.
// A push while full succeeds only if a pop happens in the same cycle;
// otherwise 'drop' flags the loss. Any DEPTH >= 2 is accepted.
module pxc_event_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] out_q,
    output logic         drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          empty, full, do_push, do_pop;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || pop);
    assign drop    = push && full && !pop;

    // Storage and pointers; pointers wrap explicitly at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                mem_q[wptr_q] <= din;
                wptr_q <= (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop)
                rptr_q <= (rptr_q == PW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // Read register: oldest entry, or zero for an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_q <= '0;
        else if (pop) out_q <= empty ? '0 : mem_q[rptr_q];
    end

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R9: a dropped push leaves the queue full
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> full);
    // R8: reading an empty queue yields zero
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (out_q == '0));
endmodule

// File: rtl/pix_trig_cell.sv
// Digital back end of one pixel cell. A hit (or an enabled test strobe)
// passes the mask, is synchronised and edge-detected, then timed by one of
// N_UNITS delay units. It is stored as {1, tag} if l1_trig is high when its
// unit expires. The tag counts trigger cycles since reset.
// Assumes inputs are quasi-static relative to the clock apart from
// disc_hit, which goes through a two-stage synchroniser.
module pix_trig_cell
    import pxc_pkg::*;
#(
    parameter int LAT_W   = 8,
    parameter int TAG_W   = 4,
    parameter int DEPTH   = 4,
    parameter int N_UNITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disc_hit,
    input  logic              test_strobe,
    input  logic              l1_trig,
    input  logic [LAT_W-1:0]  latency,
    input  logic              rd_req,
    input  logic              cfg_sin,
    input  logic              cfg_shift,
    input  logic              cfg_load,
    output logic              cfg_sout,
    output logic [TRIM_W-1:0] trim_code,
    output logic              fast_or,
    output logic [TAG_W:0]    rd_data,
    output logic              overflow
);
    localparam int EW = TAG_W + 1;

    logic               mask, test_en, raw_hit;
    logic               sync1_q, sync2_q, sync3_q, start;
    logic [N_UNITS-1:0] busy, expire, free, grant;
    logic               taken, lost_hit, match, drop;
    logic [TAG_W-1:0]   tag_q;

    pxc_cfg_chain u_cfg (
        .clk(clk), .rst_n(rst_n), .sin(cfg_sin), .shift_en(cfg_shift),
        .load(cfg_load), .sout(cfg_sout), .mask(mask), .test_en(test_en),
        .trim(trim_code)
    );

    // Masked hit source, also the fast-OR.
    assign raw_hit = !mask && (disc_hit || (test_en && test_strobe));
    assign fast_or = raw_hit;

    // Two-stage synchroniser plus a stage for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {sync1_q, sync2_q, sync3_q} <= '0;
        else        {sync1_q, sync2_q, sync3_q} <= {raw_hit, sync1_q, sync2_q};
    end
    assign start = sync2_q && !sync3_q;

    // Lowest-numbered free unit takes the new hit.
    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (!taken && free[i]) begin
                grant[i] = start;
                taken    = 1'b1;
            end
        end
    end
    assign lost_hit = start && !taken;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        pxc_delay_unit #(.LAT_W(LAT_W)) u_dly (
            .clk(clk), .rst_n(rst_n), .start(grant[g]), .latency(latency),
            .busy(busy[g]), .expire(expire[g])
        );
        assign free[g] = !busy[g] || expire[g];
    end

    assign match = (|expire) && l1_trig;

    // Event tag: counts cycles with the trigger high.
    always_ff @(posedge clk) begin
        if (!rst_n)       tag_q <= '0;
        else if (l1_trig) tag_q <= tag_q + 1'b1;
    end

    pxc_event_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(match), .din({1'b1, tag_q}),
        .pop(rd_req), .out_q(rd_data), .drop(drop)
    );

    // Sticky overflow: any lost hit or dropped event.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= overflow || lost_hit || drop;
    end

    // R6: overflow is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6: a hit finding no free unit raises overflow
    a_r6_lost_flag: assert property (@(posedge clk) disable iff (!rst_n)
        lost_hit |=> overflow);
    // R5: at most one unit is loaded per cycle
    a_r5_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R3: a masked cell never shows a fast-OR
    a_r3_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !fast_or);
endmodule

// File: tb/pix_trig_cell_tb.sv
module pix_trig_cell_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disc_hit = 0, test_strobe = 0, l1_trig = 0, rd_req = 0;
    logic [7:0] latency = 8'd4;
    logic       cfg_sin = 0, cfg_shift = 0, cfg_load = 0;
    logic       cfg_sout, fast_or, overflow;
    logic [2:0] trim_code;
    logic [4:0] rd_data;
    int checks = 0, errors = 0;
    int tcount = 0;

    always #5 clk = ~clk;

    pix_trig_cell u_dut (
        .clk(clk), .rst_n(rst_n), .disc_hit(disc_hit), .test_strobe(test_strobe),
        .l1_trig(l1_trig), .latency(latency), .rd_req(rd_req), .cfg_sin(cfg_sin),
        .cfg_shift(cfg_shift), .cfg_load(cfg_load), .cfg_sout(cfg_sout),
        .trim_code(trim_code), .fast_or(fast_or), .rd_data(rd_data),
        .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, applied at a falling edge.
    task automatic cyc(input logic d, input logic t, input logic s, input logic r);
        disc_hit = d; l1_trig = t; test_strobe = s; rd_req = r;
        @(negedge clk);
        if (t) tcount++;
        disc_hit = 0; l1_trig = 0; test_strobe = 0; rd_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        tcount = 0;
    endtask

    task automatic read_expect(input string req, input logic [4:0] exp);
        cyc(0, 0, 0, 1);
        chk(req, rd_data, exp);
    endtask

    // Word {trim, test_en, mask}, shifted most significant bit first.
    task automatic load_cfg(input logic [2:0] trim, input logic ten, input logic msk);
        logic [4:0] w;
        w = {trim, ten, msk};
        for (int i = 4; i >= 0; i--) begin
            cfg_sin = w[i]; cfg_shift = 1;
            @(negedge clk);
        end
        cfg_shift = 0; cfg_sin = 0; cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    // Hit at cycle 0 of a window, trigger at cycle toff.
    task automatic hit_pair(input int toff, input int len);
        for (int i = 0; i < len; i++) cyc(i == 0, i == toff, 0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_data", rd_data, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 fast_or", fast_or, 0);
        chk("R1 trim_code", trim_code, 0);
        chk("R1 cfg_sout", cfg_sout, 0);
    endtask

    task automatic t_fast_or();
        do_reset();
        disc_hit = 1; #1;
        chk("R2 fast_or on hit", fast_or, 1);
        disc_hit = 0; #1;
        chk("R2 fast_or idle", fast_or, 0);
        test_strobe = 1; #1;
        chk("R13 strobe without enable", fast_or, 0);
        test_strobe = 0;
        @(negedge clk);
        load_cfg(3'd0, 1'b1, 1'b0);
        test_strobe = 1; #1;
        chk("R13 strobe with enable", fast_or, 1);
        test_strobe = 0;
        @(negedge clk);
    endtask

    task automatic t_coincidence();
        do_reset();
        latency = 8'd4;
        hit_pair(7, 14);
        read_expect("R4 on-time trigger", 5'h10);
        hit_pair(8, 14);
        hit_pair(6, 14);
        read_expect("R4 late and early triggers", 5'h00);
        latency = 8'd0;
        hit_pair(3, 8);
        read_expect("R4 latency 0, tag after 3 triggers", 5'h13);
        chk("R4 no overflow", overflow, 0);
    endtask

    task automatic t_two_units();
        do_reset();
        latency = 8'd6;
        for (int i = 0; i < 16; i++) cyc(i == 0 || i == 2, i == 9 || i == 11, 0, 0);
        read_expect("R5 first unit", 5'h10);
        read_expect("R5 second unit", 5'h11);
        chk("R5 no overflow", overflow, 0);
    endtask

    task automatic t_lost_hit();
        do_reset();
        latency = 8'd10;
        for (int i = 0; i < 22; i++)
            cyc(i == 0 || i == 2 || i == 4, i == 13 || i == 15 || i == 17, 0, 0);
        chk("R6 overflow on third hit", overflow, 1);
        read_expect("R6 first kept", 5'h10);
        read_expect("R6 second kept", 5'h11);
        read_expect("R6 third dropped", 5'h00);
        idle(5);
        chk("R6 overflow sticky", overflow, 1);
    endtask

    task automatic t_full();
        do_reset();
        latency = 8'd2;
        for (int k = 0; k < 4; k++) hit_pair(5, 8);
        chk("R9 no overflow at four", overflow, 0);
        hit_pair(5, 8);
        chk("R9 overflow on fifth", overflow, 1);
        read_expect("R7 oldest first", 5'h10);
        read_expect("R7 second", 5'h11);
        read_expect("R7 third", 5'h12);
        read_expect("R7 fourth", 5'h13);
        read_expect("R8 empty read", 5'h00);
        read_expect("R8 empty read again", 5'h00);
    endtask

    task automatic t_same_cycle();
        do_reset();
        latency = 8'd2;
        for (int k = 0; k < 4; k++) hit_pair(5, 8);
        for (int i = 0; i < 8; i++) cyc(i == 0, i == 5, 0, i == 5);
        chk("R10 read during match", rd_data, 5'h10);
        chk("R10 no overflow", overflow, 0);
        read_expect("R10 next", 5'h11);
        read_expect("R10 next", 5'h12);
        read_expect("R10 next", 5'h13);
        read_expect("R10 new event kept", 5'h14);
        read_expect("R10 then empty", 5'h00);
    endtask

    task automatic t_mask();
        do_reset();
        load_cfg(3'd0, 1'b1, 1'b1);
        disc_hit = 1; #1;
        chk("R3 masked fast_or", fast_or, 0);
        disc_hit = 0; test_strobe = 1; #1;
        chk("R3 masked strobe", fast_or, 0);
        test_strobe = 0;
        @(negedge clk);
        latency = 8'd2;
        hit_pair(5, 8);
        for (int i = 0; i < 8; i++) cyc(0, i == 5, i == 0, 0);
        read_expect("R3 nothing stored", 5'h00);
    endtask

    task automatic t_test_pulse();
        do_reset();
        load_cfg(3'd0, 1'b1, 1'b0);
        latency = 8'd2;
        for (int i = 0; i < 8; i++) cyc(0, i == 5, i == 0, 0);
        read_expect("R13 strobe stored", 5'h10);
    endtask

    task automatic t_config();
        do_reset();
        for (int i = 4; i >= 0; i--) begin
            cfg_sin = (5'b10100 >> i) & 1; cfg_shift = 1;
            @(negedge clk);
        end
        cfg_shift = 0;
        chk("R12 no change before load", trim_code, 0);
        chk("R11 first bit at sout", cfg_sout, 1);
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
        chk("R11 trim loaded", trim_code, 3'd5);
        cfg_sin = 0; cfg_shift = 1;
        @(negedge clk);
        chk("R11 second bit at sout", cfg_sout, 0);
        @(negedge clk);
        chk("R11 third bit at sout", cfg_sout, 1);
        repeat (3) @(negedge clk);
        cfg_shift = 0;
        chk("R12 trim holds while shifting", trim_code, 3'd5);
        latency = 8'd2;
        hit_pair(5, 8);
        read_expect("R12 cell still unmasked", 5'h10);
        chk("R12 trim holds after traffic", trim_code, 3'd5);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fast_or();
        t_coincidence();
        t_two_units();
        t_lost_hit();
        t_full();
        t_same_cycle();
        t_mask();
        t_test_pulse();
        t_config();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule